// File: doc/BRIEF.md
# Multi-Sector Transfer Sequencer

This block runs the bookkeeping side of a disk sector transfer. A controller gives it one start pulse together with a transfer mode, a starting track and sector, a sector-count value, the sectors-per-track setting, an active-low side select and a 24-bit memory base address. The block then requests one sector at a time from a sector-access agent over a valid/ready request channel. It waits for a valid/ready response that reports success or failure. After each success it moves to the next sector position, decrements the sector count and moves the memory pointer forward by one sector.

When the last sector is done, the block passes through one completion state. It then raises `done` and `spin_down` for one cycle with `error` low. A failed access stops the command at once with `error` set. The block does not move media or data. It only decides what is asked for next and where in memory the data belongs.

Back-pressure works as follows. A request is offered with `req_valid`. All of its fields hold steady until `req_ready` accepts it. After acceptance the block raises `resp_ready` and waits as long as needed for `resp_valid`. Only one request is ever outstanding.

Top module: `sector_xfer_seq`

## Requirements
- R1: `mode` selects the number of sectors. Code 2'b00 transfers exactly one sector, and so does the reserved code 2'b11. Code 2'b01 transfers `cnt_in` sectors. `req_write` carries `wr_en` as it was latched at start.
- R2: Mode code 2'b10 (whole track) transfers `spt` sectors.
- R3: `req_side` is the inverse of `side_sel_n` as it was at the accepted start. Later changes of `side_sel_n` have no effect until the next start.
- R4: Sector numbers start from `sec_in` and increment after each successful sector. After a success at a sector number of `spt` or above, the sector returns to 1 and the track increments.
- R5: `sec_count` loads `cnt_in` at start. Each successful sector decrements it, and it saturates at zero.
- R6: `req_addr` loads `dma_base` at start. Each successful sector adds 512 to it, modulo 2^24.
- R7: A failure response (`resp_ok`=0) ends the command. In the next cycle `done`, `spin_down` and `error` are high and `busy` is low. No further request is issued.
- R8: After the last successful response the block spends one cycle in a completion state. `done` and `spin_down` are then high for exactly one cycle, with `error` low.
- R9: Only one request is outstanding. `req_valid` drops in the cycle after acceptance and returns only after a response. While `req_valid` waits without `req_ready`, the request fields stay stable.
- R10: A start whose sector total is zero issues no request. `done` rises two cycles after the start with `error` low.
- R11: A start pulse while `busy` is high is ignored.
- R12: After reset the outputs are: `busy`, `done`, `error` and `req_valid` low, track 0, sector 1, count 0, address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only when idle |
| mode | input | 2 | Transfer mode code |
| wr_en | input | 1 | 1 for a write transfer, 0 for a read |
| trk_in | input | 8 | Starting track |
| sec_in | input | 8 | Starting sector (1-based) |
| cnt_in | input | 8 | Sector-count register load value |
| spt | input | 8 | Sectors per track |
| side_sel_n | input | 1 | Active-low side select |
| dma_base | input | 24 | Starting memory address |
| req_valid | output | 1 | Sector request offered |
| req_ready | input | 1 | Request accepted by the agent |
| req_track | output | 8 | Track of the current sector |
| req_sector | output | 8 | Current sector number |
| req_side | output | 1 | Latched side |
| req_write | output | 1 | Latched direction |
| req_addr | output | 24 | Memory address of the current sector |
| resp_valid | input | 1 | Response offered by the agent |
| resp_ready | output | 1 | Block waits for a response |
| resp_ok | input | 1 | Response outcome, 1 for success |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Last command ended on a failure |
| spin_down | output | 1 | One-cycle motor spin-down request |
| sec_count | output | 8 | Sector-count register |
| dma_addr | output | 24 | Memory pointer |

## Verification
The hardest case to reach is a failure in the middle of a multi-sector run that also has to pass the sector wrap. The responder therefore takes a failure index per command, so the N-th response of that command returns failure. That command starts a few sectors before the end of a track. The same run stalls `req_ready` in a pattern, so that requests sit unaccepted for several cycles. It also toggles `side_sel_n` and pulses `start` while the command is in flight. This exercises field stability, the latched side and the ignored start in one pass.

// File: rtl/sxs_pkg.sv
package sxs_pkg;
  typedef enum logic [1:0] {
    XM_SINGLE = 2'b00,
    XM_MULTI  = 2'b01,
    XM_TRACK  = 2'b10,
    XM_RSVD   = 2'b11
  } xfer_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_FIN   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/sxs_position.sv
module sxs_position #(
  parameter int NUM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NUM_W-1:0] ld_track,
  input  logic [NUM_W-1:0] ld_sector,
  input  logic             ld_side,
  input  logic             advance,
  input  logic [NUM_W-1:0] spt,
  output logic [NUM_W-1:0] track,
  output logic [NUM_W-1:0] sector,
  output logic             side
);
  localparam logic [NUM_W-1:0] ONE = NUM_W'(1);

  logic wrap;
  assign wrap = (sector >= spt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      track  <= '0;
      sector <= ONE;
      side   <= 1'b0;
    end else if (load) begin
      track  <= ld_track;
      sector <= ld_sector;
      side   <= ld_side;
    end else if (advance) begin
      if (wrap) begin
        sector <= ONE;
        track  <= track + ONE;
      end else begin
        sector <= sector + ONE;
      end
    end
  end
endmodule

// File: rtl/sxs_counters.sv
module sxs_counters #(
  parameter int NUM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NUM_W-1:0] ld_count,
  input  logic [NUM_W-1:0] ld_remain,
  input  logic             step,
  output logic [NUM_W-1:0] count,
  output logic             last
);
  localparam logic [NUM_W-1:0] ONE = NUM_W'(1);

  logic [NUM_W-1:0] remain;

  assign last = (remain == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      remain <= '0;
    end else if (load) begin
      count  <= ld_count;
      remain <= ld_remain;
    end else if (step) begin
      count  <= (count == '0) ? '0 : count - ONE;
      remain <= (remain == '0) ? '0 : remain - ONE;
    end
  end
endmodule

// File: rtl/sxs_dma_ptr.sv
module sxs_dma_ptr #(
  parameter int ADDR_W    = 24,
  parameter int SEC_BYTES = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(SEC_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr <= '0;
    else if (load)  addr <= base;
    else if (step)  addr <= addr + STRIDE;
  end
endmodule

// File: rtl/sector_xfer_seq.sv
module sector_xfer_seq
  import sxs_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int NUM_W     = 8,
  parameter int SEC_BYTES = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic              wr_en,
  input  logic [NUM_W-1:0]  trk_in,
  input  logic [NUM_W-1:0]  sec_in,
  input  logic [NUM_W-1:0]  cnt_in,
  input  logic [NUM_W-1:0]  spt,
  input  logic              side_sel_n,
  input  logic [ADDR_W-1:0] dma_base,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [NUM_W-1:0]  req_track,
  output logic [NUM_W-1:0]  req_sector,
  output logic              req_side,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              resp_valid,
  output logic              resp_ready,
  input  logic              resp_ok,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              spin_down,
  output logic [NUM_W-1:0]  sec_count,
  output logic [ADDR_W-1:0] dma_addr
);
  seq_state_e       state, state_nx;
  xfer_mode_e       mode_e;
  logic             accept, resp_hit, step_ok, step_bad, last;
  logic [NUM_W-1:0] remain_init;
  logic             done_q, err_q, write_q;

  assign mode_e   = xfer_mode_e'(mode);
  assign accept   = start && (state == ST_IDLE);
  assign resp_hit = resp_valid && (state == ST_WAIT);
  assign step_ok  = resp_hit && resp_ok;
  assign step_bad = resp_hit && !resp_ok;

  always_comb begin
    unique case (mode_e)
      XM_MULTI: remain_init = cnt_in;
      XM_TRACK: remain_init = spt;
      default:  remain_init = NUM_W'(1);
    endcase
  end

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (accept) state_nx = (remain_init == '0) ? ST_FIN : ST_ISSUE;
      ST_ISSUE: if (req_ready) state_nx = ST_WAIT;
      ST_WAIT: begin
        if (step_ok)       state_nx = last ? ST_FIN : ST_ISSUE;
        else if (step_bad) state_nx = ST_IDLE;
      end
      ST_FIN:   state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      write_q <= 1'b0;
    end else begin
      state  <= state_nx;
      done_q <= (state == ST_FIN) || step_bad;
      if (accept) begin
        err_q   <= 1'b0;
        write_q <= wr_en;
      end else if (step_bad) begin
        err_q <= 1'b1;
      end
    end
  end

  sxs_position #(.NUM_W(NUM_W)) u_pos (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .ld_track  (trk_in),
    .ld_sector (sec_in),
    .ld_side   (~side_sel_n),
    .advance   (step_ok),
    .spt       (spt),
    .track     (req_track),
    .sector    (req_sector),
    .side      (req_side)
  );

  sxs_counters #(.NUM_W(NUM_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .ld_count  (cnt_in),
    .ld_remain (remain_init),
    .step      (step_ok),
    .count     (sec_count),
    .last      (last)
  );

  sxs_dma_ptr #(.ADDR_W(ADDR_W), .SEC_BYTES(SEC_BYTES)) u_dma (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .base  (dma_base),
    .step  (step_ok),
    .addr  (dma_addr)
  );

  assign req_valid  = (state == ST_ISSUE);
  assign resp_ready = (state == ST_WAIT);
  assign busy       = (state != ST_IDLE);
  assign req_write  = write_q;
  assign req_addr   = dma_addr;
  assign done       = done_q;
  assign spin_down  = done_q;
  assign error      = err_q;
endmodule

// File: rtl/sxs_checks.sv
module sxs_checks #(
  parameter int ADDR_W    = 24,
  parameter int NUM_W     = 8,
  parameter int SEC_BYTES = 512
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [1:0]        mode,
  input logic [NUM_W-1:0]  cnt_in,
  input logic              req_valid,
  input logic              req_ready,
  input logic [NUM_W-1:0]  req_track,
  input logic [NUM_W-1:0]  req_sector,
  input logic [ADDR_W-1:0] req_addr,
  input logic              resp_valid,
  input logic              resp_ready,
  input logic              resp_ok,
  input logic              busy,
  input logic              done,
  input logic              error,
  input logic [NUM_W-1:0]  sec_count,
  input logic [ADDR_W-1:0] dma_addr
);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(SEC_BYTES);
  localparam logic [NUM_W-1:0]  ONE    = NUM_W'(1);

  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_valid);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_track) &&
                                   $stable(req_sector) && $stable(req_addr)));

  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_ready && resp_ok) |=> (dma_addr == $past(dma_addr) + STRIDE));

  a_r5_count_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_ready && resp_ok) |=>
      (sec_count == (($past(sec_count) == '0) ? '0 : $past(sec_count) - ONE)));

  a_r7_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_ready && !resp_ok) |=> (done && error && !busy));

  a_r10_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mode == 2'b01 && cnt_in == '0) |=> (busy && !req_valid) ##1 (done && !error));
endmodule

bind sector_xfer_seq sxs_checks #(.ADDR_W(ADDR_W), .NUM_W(NUM_W), .SEC_BYTES(SEC_BYTES)) u_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .mode       (mode),
  .cnt_in     (cnt_in),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_track  (req_track),
  .req_sector (req_sector),
  .req_addr   (req_addr),
  .resp_valid (resp_valid),
  .resp_ready (resp_ready),
  .resp_ok    (resp_ok),
  .busy       (busy),
  .done       (done),
  .error      (error),
  .sec_count  (sec_count),
  .dma_addr   (dma_addr)
);

// File: tb/sector_xfer_seq_test.sv
module sector_xfer_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        wr_en = 1'b0;
  logic [7:0]  trk_in = 8'd0, sec_in = 8'd1, cnt_in = 8'd0, spt = 8'd9;
  logic        side_sel_n = 1'b1;
  logic [23:0] dma_base = 24'd0;
  logic        req_valid, req_ready;
  logic [7:0]  req_track, req_sector;
  logic        req_side, req_write;
  logic [23:0] req_addr;
  logic        resp_valid = 1'b0, resp_ready, resp_ok = 1'b1;
  logic        busy, done, error, spin_down;
  logic [7:0]  sec_count;
  logic [23:0] dma_addr;

  always #10 clk = ~clk;

  sector_xfer_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .wr_en(wr_en),
    .trk_in(trk_in), .sec_in(sec_in), .cnt_in(cnt_in), .spt(spt),
    .side_sel_n(side_sel_n), .dma_base(dma_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_track(req_track),
    .req_sector(req_sector), .req_side(req_side), .req_write(req_write),
    .req_addr(req_addr), .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_ok(resp_ok), .busy(busy), .done(done), .error(error),
    .spin_down(spin_down), .sec_count(sec_count), .dma_addr(dma_addr)
  );

  int total = 0, bad = 0;
  int n_req = 0, n_done = 0, n_resp = 0, fail_idx = -1, stall = 0, lat = 1, dly = 0, cyc = 0;

  // behavioural reference model
  int m_state = 0, m_track = 0, m_sector = 1, m_side = 0, m_write = 0;
  int m_count = 0, m_rem = 0, m_addr = 0, m_done = 0, m_err = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_track = 0; m_sector = 1; m_side = 0; m_write = 0;
      m_count = 0; m_rem = 0; m_addr = 0; m_done = 0; m_err = 0;
    end else begin
      if (req_valid && req_ready) n_req++;
      if (done) n_done++;
      m_done = 0;
      case (m_state)
        0: if (start) begin
          m_track = trk_in; m_sector = sec_in; m_side = !side_sel_n;
          m_write = wr_en; m_count = cnt_in; m_addr = dma_base; m_err = 0;
          m_rem = (mode == 2'b01) ? int'(cnt_in) : (mode == 2'b10) ? int'(spt) : 1;
          m_state = (m_rem == 0) ? 3 : 1;
        end
        1: if (req_ready) m_state = 2;
        2: if (resp_valid) begin
          if (resp_ok) begin
            if (m_sector >= spt) begin m_sector = 1; m_track = (m_track + 1) % 256; end
            else m_sector = m_sector + 1;
            if (m_count > 0) m_count = m_count - 1;
            m_addr = (m_addr + 512) % (1 << 24);
            m_rem = m_rem - 1;
            m_state = (m_rem == 0) ? 3 : 1;
          end else begin
            m_err = 1; m_done = 1; m_state = 0;
          end
        end
        default: begin m_done = 1; m_state = 0; end
      endcase
    end
  end

  // responder and per-cycle comparison, both on the falling edge
  always @(negedge clk) begin
    cyc++;
    req_ready <= (stall > 1) ? ((cyc % stall) == 0) : 1'b1;
    if (resp_valid) begin
      resp_valid <= 1'b0;
    end else if (resp_ready) begin
      if (dly >= lat) begin
        resp_valid <= 1'b1;
        resp_ok    <= (n_resp != fail_idx);
        n_resp++;
        dly = 0;
      end else dly++;
    end
    if (rst_n) begin
      chk(req_valid == (m_state == 1) && resp_ready == (m_state == 2), "R9 handshake", int'(req_valid), int'(m_state == 1));
      chk(busy == (m_state != 0), "R11 busy", int'(busy), int'(m_state != 0));
      chk(req_track == m_track && req_sector == m_sector, "R4 position", int'(req_sector), m_sector);
      chk(req_side == m_side, "R3 side", int'(req_side), m_side);
      chk(req_write == m_write, "R1 direction", int'(req_write), m_write);
      chk(sec_count == m_count, "R5 count", int'(sec_count), m_count);
      chk(dma_addr == m_addr && req_addr == m_addr, "R6 address", int'(dma_addr), m_addr);
      chk(done == m_done && spin_down == m_done, "R8 done", int'(done), m_done);
      chk(error == m_err, "R7 error", int'(error), m_err);
    end
  end

  task automatic run_cmd(input logic [1:0] md, input logic w, input int trk, input int sec,
                         input int cnt, input int sp, input logic sn, input int base,
                         input int fail, input int exp_req, input int stl, input int poke,
                         input string tag);
    @(negedge clk);
    mode = md; wr_en = w; trk_in = 8'(trk); sec_in = 8'(sec); cnt_in = 8'(cnt);
    spt = 8'(sp); side_sel_n = sn; dma_base = 24'(base);
    fail_idx = fail; stall = stl; n_req = 0; n_resp = 0; n_done = 0; dly = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 3000 && n_done == 0; i++) begin
      if (i == poke) begin
        start = 1'b1; side_sel_n = ~sn; trk_in = 8'd200; dma_base = 24'h777000;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(n_req == exp_req, {tag, " request total"}, n_req, exp_req);
    chk(n_done == 1, {tag, " single done pulse"}, n_done, 1);
    chk(error == (fail >= 0), {tag, " final error"}, int'(error), int'(fail >= 0));
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk(!busy && !done && !error && !req_valid, "R12 reset flags", int'(busy), 0);
    chk(req_track == 0 && req_sector == 1 && sec_count == 0 && dma_addr == 0, "R12 reset regs", int'(req_sector), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 single read, side input low means side 1 (R3)
    run_cmd(2'b00, 1'b0, 5, 3, 4, 9, 1'b0, 24'h010000, -1, 1, 0, -1, "R1 single");
    chk(req_side == 1'b1, "R3 latched side", int'(req_side), 1);
    // R1/R4 multi write across a track wrap with ready stalls
    run_cmd(2'b01, 1'b1, 2, 7, 5, 9, 1'b1, 24'h020000, -1, 5, 3, -1, "R1 multi");
    chk(req_track == 3 && req_sector == 3, "R4 wrap result", int'(req_sector), 3);
    chk(dma_addr == 24'h020000 + 5 * 512, "R6 final address", int'(dma_addr), 24'h020000 + 5 * 512);
    // R2 whole track, count saturates (R5)
    run_cmd(2'b10, 1'b0, 10, 1, 3, 10, 1'b1, 24'hFFFE00, -1, 10, 0, -1, "R2 track");
    chk(sec_count == 0, "R5 saturated", int'(sec_count), 0);
    chk(dma_addr == 24'(24'hFFFE00 + 10 * 512), "R6 address wrap", int'(dma_addr), int'(24'(24'hFFFE00 + 10 * 512)));
    // R7 failure at the third sector, with start poke and side toggle (R11, R3)
    run_cmd(2'b01, 1'b1, 40, 8, 6, 9, 1'b1, 24'h030000, 2, 3, 2, 4, "R7 abort");
    chk(dma_addr == 24'h030000 + 2 * 512, "R7 address frozen", int'(dma_addr), 24'h030000 + 2 * 512);
    chk(req_side == 1'b0, "R3 side ignored", int'(req_side), 0);
    chk(req_track == 41, "R11 start ignored", int'(req_track), 41);
    // R10 zero count
    run_cmd(2'b01, 1'b0, 1, 1, 0, 9, 1'b1, 24'h040000, -1, 0, 0, -1, "R10 zero");
    // R5 single with zero count stays zero; reserved code acts as single (R1)
    run_cmd(2'b11, 1'b0, 0, 9, 0, 9, 1'b1, 24'h050000, -1, 1, 2, -1, "R1 reserved");
    chk(sec_count == 0 && req_sector == 1 && req_track == 1, "R5 single zero count", int'(sec_count), 0);
    // R8 longer latency on a clean multi run
    lat = 4;
    run_cmd(2'b01, 1'b0, 7, 1, 2, 9, 1'b1, 24'h060000, -1, 2, 0, -1, "R8 complete");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule